// File: doc/BRIEF.md
# Byte-Wide Command Queue with Word Readback

This block queues command bytes for a flash command engine. Software deposits commands through a 64-bit register. Each accepted write adds exactly eight bytes, and software pads a short sequence with idle command bytes. A downstream execution unit takes the bytes one at a time through a valid/ready pair. The queue reports how many bytes are still unfilled. It keeps three sticky status flags (drained, filled, overrun), and a per-flag enable mask gates them onto one interrupt line.

Usable capacity depends on the operating mode. While the boot-phase input is low the queue holds 256 bytes. When that input rises the queue is emptied and its capacity grows to 1536 bytes in the same cycle. A flush control empties the queue on request. A hold control lets the execution unit finish the bytes already queued and then keeps it parked, even if new bytes arrive, until the hold is released.

Software can also drain the queue back out for inspection. Pulsing a start control makes the queue present its next eight bytes on the readback word and raise a valid flag. Software acknowledges each word with a read strobe. A done flag marks the last word. While readback runs, byte delivery to the execution unit pauses at the next 8-byte boundary.

Top module: `cmd_byte_fifo`

## Requirements
- R1: After reset with `boot_off` low: `free_bytes` is 256, `status` is 0, `irq` is 0, and `pop_valid`, `rb_busy`, `rb_valid` and `rb_done` are all 0.
- R2: A write on `wr_valid` with room stores eight bytes. `wr_data[7:0]` is delivered first and `wr_data[63:56]` last. Bytes leave in write order, one per cycle in which `pop_valid` and `pop_ready` are both high. `pop_valid` rises the cycle after the write into an empty queue.
- R3: `free_bytes` equals the current capacity minus the bytes held. It is updated in the cycle after each write, pop, readback transfer or flush.
- R4: A write arriving when fewer than eight bytes are free is discarded and leaves the contents and `free_bytes` unchanged. It sets overrun flag `status[2]`.
- R5: `status[1]` sets when an accepted write makes the held count equal to capacity. `status[0]` sets when a pop removes the last held byte. Each flag stays set until a 1 on the matching `stat_clr` bit clears it, and a new event in the same cycle wins over the clear.
- R6: `irq` is high exactly when some bit of `status & irq_en` is set, and it changes in the same cycle as `status`.
- R7: After a pulse on `rb_start`, each time `rb_valid` is low at an 8-byte boundary the next eight queued bytes move to `rb_word` (first byte in bits [7:0]) and leave the queue, and `rb_valid` rises. A `cmd_rd` pulse clears `rb_valid`. `rb_done` sets together with the last word, or at once if the queue is empty, and `rb_busy` then falls. `rb_done_clr` clears `rb_done`.
- R8: While `rb_busy` is high, the execution unit still receives the rest of a partially consumed 8-byte group, and then `pop_valid` stays low.
- R9: Any write on `wr_valid` clears `rb_busy` in the next cycle, so that byte delivery resumes.
- R10: A pulse on `flush_req` empties the queue. In the next cycle `pop_valid` is 0 and `free_bytes` equals the capacity. A write in the flush cycle is dropped.
- R11: While `boot_off` is low the capacity is 256 bytes. A 0-to-1 change of `boot_off` empties the queue, and the next cycle shows `free_bytes` = 1536. After that, more than 256 bytes can be held without overrun.
- R12: While `exec_hold` is high, the bytes already queued are still delivered. Once the queue has drained, `pop_valid` stays low for new writes until `exec_hold` returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_off | input | 1 | 0 = boot phase (256 bytes), 1 = normal phase (1536 bytes); rising edge flushes |
| flush_req | input | 1 | Pulse: empty the queue |
| exec_hold | input | 1 | Park the execution unit once the queued bytes are gone |
| wr_valid | input | 1 | Software write of eight command bytes |
| wr_data | input | 64 | Command bytes, first byte in [7:0] |
| pop_ready | input | 1 | Execution unit accepts the offered byte |
| pop_valid | output | 1 | A byte is offered to the execution unit |
| pop_byte | output | 8 | Offered command byte |
| free_bytes | output | 11 | Unfilled byte count |
| stat_clr | input | 3 | Write-1-to-clear for the status flags |
| irq_en | input | 3 | Per-flag interrupt enable |
| status | output | 3 | [0] drained, [1] filled, [2] overrun |
| irq | output | 1 | Interrupt request |
| rb_start | input | 1 | Pulse: begin readback |
| cmd_rd | input | 1 | Software has read `rb_word` |
| rb_done_clr | input | 1 | Clear `rb_done` |
| rb_busy | output | 1 | Readback in progress |
| rb_valid | output | 1 | `rb_word` holds a fresh group of eight bytes |
| rb_done | output | 1 | Final readback word delivered |
| rb_word | output | 64 | Readback word |

## Verification
A wrong byte pointer or group offset shows up on `pop_byte` at the very next pop, and on `rb_word` at the next readback transfer. Both appear as bytes out of write order. A held count that drifts appears on `free_bytes` one cycle after the faulty update. Later it also appears as a `status` flag set too early or too late: filled at the wrong write, overrun on a legal write, or drained before the last byte. Freeze and hold faults appear on `pop_valid` within a cycle of the boundary where delivery should stop or restart.

// File: rtl/cbf_pkg.sv
package cbf_pkg;
  localparam int ST_W     = 3;
  localparam int ST_EMPTY = 0;
  localparam int ST_FULL  = 1;
  localparam int ST_OVF   = 2;
  localparam int GRP_B    = 8;   // bytes per software word
  localparam int WORD_W   = 64;
endpackage

// File: rtl/cbf_mem.sv
module cbf_mem #(
  parameter int DEPTH = 192,
  parameter int DW    = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/cbf_readback.sv
module cbf_readback #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wr_any,
  input  logic          cmd_rd,
  input  logic          done_clr,
  input  logic          flush,
  input  logic          aligned,
  input  logic          have_word,
  input  logic          last_word,
  input  logic [DW-1:0] word_in,
  output logic          take,
  output logic          busy,
  output logic          valid,
  output logic          done,
  output logic [DW-1:0] word
);
  logic empty_end, finish;

  assign take      = busy && !valid && aligned && have_word && !wr_any && !flush;
  assign empty_end = busy && aligned && !have_word && !wr_any && !flush;
  assign finish    = (take && last_word) || empty_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      valid <= 1'b0;
      done  <= 1'b0;
      word  <= '0;
    end else begin
      if (wr_any)      busy <= 1'b0;
      else if (finish) busy <= 1'b0;
      else if (start)  busy <= 1'b1;

      if (take)        valid <= 1'b1;
      else if (cmd_rd) valid <= 1'b0;

      if (finish)        done <= 1'b1;
      else if (done_clr) done <= 1'b0;

      if (take) word <= word_in;
    end
  end
endmodule

// File: rtl/cbf_status.sv
module cbf_status #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ev,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] en,
  output logic [W-1:0] flags,
  output logic         irq
);
  logic [W-1:0] flags_nx;

  assign flags_nx = (flags & ~clr) | ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= flags_nx;
      irq   <= |(flags_nx & en);
    end
  end
endmodule

// File: rtl/cmd_byte_fifo.sv
module cmd_byte_fifo
  import cbf_pkg::*;
#(
  parameter int  CAP_BOOT = 256,
  parameter int  CAP_RUN  = 1536,
  localparam int CNT_W    = $clog2(CAP_RUN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_off,
  input  logic              flush_req,
  input  logic              exec_hold,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              pop_ready,
  output logic              pop_valid,
  output logic [7:0]        pop_byte,
  output logic [CNT_W-1:0]  free_bytes,
  input  logic [ST_W-1:0]   stat_clr,
  input  logic [ST_W-1:0]   irq_en,
  output logic [ST_W-1:0]   status,
  output logic              irq,
  input  logic              rb_start,
  input  logic              cmd_rd,
  input  logic              rb_done_clr,
  output logic              rb_busy,
  output logic              rb_valid,
  output logic              rb_done,
  output logic [WORD_W-1:0] rb_word
);
  localparam int DEPTH_W = CAP_RUN / GRP_B;
  localparam int PW      = $clog2(DEPTH_W);
  localparam int OW      = $clog2(GRP_B);
  localparam logic [CNT_W:0] C_BOOT = (CNT_W+1)'(CAP_BOOT);
  localparam logic [CNT_W:0] C_RUN  = (CNT_W+1)'(CAP_RUN);
  localparam logic [CNT_W:0] C_GRP  = (CNT_W+1)'(GRP_B);

  logic [CNT_W-1:0]  count;
  logic [PW-1:0]     wr_word, rd_word;
  logic [OW-1:0]     rd_off;
  logic              stopped, mode_q;
  logic              flush, aligned, wr_ok, pop, take;
  logic [CNT_W:0]    cap_now, cnt_ext, cnt_nx;
  logic [WORD_W-1:0] head_word;
  logic [ST_W-1:0]   ev;

  assign flush   = flush_req | (boot_off & ~mode_q);
  assign cap_now = boot_off ? C_RUN : C_BOOT;
  assign cnt_ext = {1'b0, count};
  assign aligned = (rd_off == '0);
  assign wr_ok   = wr_valid && !flush && ((cnt_ext + C_GRP) <= cap_now);

  assign pop_valid = (count != '0) && !(stopped && exec_hold) && !(rb_busy && aligned);
  assign pop       = pop_valid && pop_ready && !flush;
  assign pop_byte  = head_word[rd_off*8 +: 8];

  always_comb begin
    cnt_nx = cnt_ext;
    if (wr_ok) cnt_nx = cnt_nx + C_GRP;
    if (pop)   cnt_nx = cnt_nx - 1'b1;
    if (take)  cnt_nx = cnt_nx - C_GRP;
    if (flush) cnt_nx = '0;
  end

  always_comb begin
    ev = '0;
    ev[ST_EMPTY] = pop && (count == CNT_W'(1));
    ev[ST_FULL]  = wr_ok && (cnt_nx == cap_now);
    ev[ST_OVF]   = wr_valid && !flush && !wr_ok;
  end

  cbf_mem #(.DEPTH(DEPTH_W), .DW(WORD_W)) u_mem (
    .clk   (clk),
    .we    (wr_ok),
    .waddr (wr_word),
    .wdata (wr_data),
    .raddr (rd_word),
    .rdata (head_word)
  );

  cbf_readback #(.DW(WORD_W)) u_rb (
    .clk       (clk),
    .rst       (rst),
    .start     (rb_start),
    .wr_any    (wr_valid),
    .cmd_rd    (cmd_rd),
    .done_clr  (rb_done_clr),
    .flush     (flush),
    .aligned   (aligned),
    .have_word (count != '0),
    .last_word (count == CNT_W'(GRP_B)),
    .word_in   (head_word),
    .take      (take),
    .busy      (rb_busy),
    .valid     (rb_valid),
    .done      (rb_done),
    .word      (rb_word)
  );

  cbf_status #(.W(ST_W)) u_st (
    .clk   (clk),
    .rst   (rst),
    .ev    (ev),
    .clr   (stat_clr),
    .en    (irq_en),
    .flags (status),
    .irq   (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      count      <= '0;
      free_bytes <= CNT_W'(CAP_BOOT);
      wr_word    <= '0;
      rd_word    <= '0;
      rd_off     <= '0;
      stopped    <= 1'b0;
      mode_q     <= 1'b0;
    end else begin
      mode_q     <= boot_off;
      count      <= cnt_nx[CNT_W-1:0];
      free_bytes <= (cap_now > cnt_nx) ? CNT_W'(cap_now - cnt_nx) : '0;
      stopped    <= exec_hold && (stopped || (count == '0));
      if (flush) begin
        wr_word <= '0;
        rd_word <= '0;
        rd_off  <= '0;
      end else begin
        if (wr_ok)
          wr_word <= (wr_word == PW'(DEPTH_W-1)) ? '0 : wr_word + 1'b1;
        if (pop) begin
          rd_off <= rd_off + 1'b1;
          if (rd_off == OW'(GRP_B-1))
            rd_word <= (rd_word == PW'(DEPTH_W-1)) ? '0 : rd_word + 1'b1;
        end else if (take) begin
          rd_word <= (rd_word == PW'(DEPTH_W-1)) ? '0 : rd_word + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cbf_checker.sv
module cbf_checker #(
  parameter int  CAP_BOOT = 256,
  parameter int  CAP_RUN  = 1536,
  localparam int CNT_W    = $clog2(CAP_RUN + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             boot_off,
  input logic             wr_valid,
  input logic             flush,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W:0]   cap_now,
  input logic [CNT_W-1:0] free_bytes,
  input logic             pop_valid,
  input logic             exec_hold,
  input logic             stopped,
  input logic             rb_busy,
  input logic             aligned,
  input logic             cmd_rd,
  input logic             rb_valid
);
  AST_FREE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    !$past(boot_off) |-> (free_bytes <= CNT_W'(CAP_BOOT))); // R3

  AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !flush && (({1'b0, count} + 8) > cap_now)) |=> (count <= $past(count))); // R4

  AST_RB_ACK: assert property (@(posedge clk) disable iff (rst)
    (cmd_rd && rb_valid) |=> !rb_valid); // R7

  AST_FREEZE_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (rb_busy && aligned) |-> !pop_valid); // R8

  AST_WRITE_ENDS_RB: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !rb_busy); // R9

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0)); // R10

  AST_HOLD_PARKS: assert property (@(posedge clk) disable iff (rst)
    (stopped && exec_hold) |-> !pop_valid); // R12
endmodule

bind cmd_byte_fifo cbf_checker #(.CAP_BOOT(CAP_BOOT), .CAP_RUN(CAP_RUN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .boot_off   (boot_off),
  .wr_valid   (wr_valid),
  .flush      (flush),
  .count      (count),
  .cap_now    (cap_now),
  .free_bytes (free_bytes),
  .pop_valid  (pop_valid),
  .exec_hold  (exec_hold),
  .stopped    (stopped),
  .rb_busy    (rb_busy),
  .aligned    (aligned),
  .cmd_rd     (cmd_rd),
  .rb_valid   (rb_valid)
);

// File: tb/cmd_byte_fifo_tb.sv
module cmd_byte_fifo_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        boot_off = 0, flush_req = 0, exec_hold = 0, wr_valid = 0;
  logic [63:0] wr_data = '0;
  logic        pop_ready = 0, pop_valid;
  logic [7:0]  pop_byte;
  logic [10:0] free_bytes;
  logic [2:0]  stat_clr = '0, irq_en = '0, status;
  logic        irq, rb_start = 0, cmd_rd = 0, rb_done_clr = 0;
  logic        rb_busy, rb_valid, rb_done;
  logic [63:0] rb_word;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_byte_fifo u_dut (
    .clk(clk), .rst(rst), .boot_off(boot_off), .flush_req(flush_req),
    .exec_hold(exec_hold), .wr_valid(wr_valid), .wr_data(wr_data),
    .pop_ready(pop_ready), .pop_valid(pop_valid), .pop_byte(pop_byte),
    .free_bytes(free_bytes), .stat_clr(stat_clr), .irq_en(irq_en),
    .status(status), .irq(irq), .rb_start(rb_start), .cmd_rd(cmd_rd),
    .rb_done_clr(rb_done_clr), .rb_busy(rb_busy), .rb_valid(rb_valid),
    .rb_done(rb_done), .rb_word(rb_word)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr64(input logic [63:0] d);
    wr_valid = 1'b1; wr_data = d;
    tick();
    wr_valid = 1'b0;
  endtask

  task automatic pop_one(input logic [7:0] exp, input string tag);
    chk({tag, " pop_valid"}, 64'(pop_valid), 64'd1);
    chk({tag, " pop_byte"}, 64'(pop_byte), 64'(exp));
    pop_ready = 1'b1;
    tick();
    pop_ready = 1'b0;
  endtask

  task automatic clear_all();
    flush_req = 1'b1; stat_clr = 3'b111; rb_done_clr = 1'b1;
    tick();
    flush_req = 1'b0; stat_clr = '0; rb_done_clr = 1'b0;
  endtask

  task automatic rb_get(input logic [63:0] exp, input logic exp_done, input string tag);
    for (int i = 0; i < 6 && !rb_valid; i++) tick();
    chk({tag, " rb_valid"}, 64'(rb_valid), 64'd1);
    chk({tag, " rb_word"}, rb_word, exp);
    chk({tag, " rb_done"}, 64'(rb_done), 64'(exp_done));
    cmd_rd = 1'b1;
    tick();
    cmd_rd = 1'b0;
    chk({tag, " rb_valid cleared"}, 64'(rb_valid), 64'd0);
  endtask

  task automatic t_reset();
    chk("R1 free", 64'(free_bytes), 64'd256);
    chk("R1 status", 64'(status), 64'd0);
    chk("R1 irq", 64'(irq), 64'd0);
    chk("R1 pop_valid", 64'(pop_valid), 64'd0);
    chk("R1 rb flags", {61'd0, rb_busy, rb_valid, rb_done}, 64'd0);
  endtask

  task automatic t_order();
    logic [63:0] w = 64'h0807_0605_0403_0201;
    wr64(w);
    chk("R2 pop_valid after write", 64'(pop_valid), 64'd1);
    chk("R3 free after write", 64'(free_bytes), 64'd248);
    for (int i = 0; i < 3; i++) pop_one(w[8*i +: 8], "R2 order");
    chk("R3 free after 3 pops", 64'(free_bytes), 64'd251);
    for (int i = 3; i < 7; i++) pop_one(w[8*i +: 8], "R2 order");
    chk("R5 empty not yet", 64'(status[0]), 64'd0);
    pop_one(w[63:56], "R2 last");
    chk("R5 empty flag", 64'(status[0]), 64'd1);
    chk("R2 drained", 64'(pop_valid), 64'd0);
    stat_clr = 3'b001; tick(); stat_clr = '0;
    chk("R5 w1c clear", 64'(status), 64'd0);
  endtask

  task automatic t_full();
    for (int i = 1; i <= 32; i++) wr64({8{8'(i)}});
    chk("R5 full flag", 64'(status), 64'b010);
    chk("R3 free zero", 64'(free_bytes), 64'd0);
    wr64(64'hDEAD_BEEF_DEAD_BEEF);
    chk("R4 overrun flag", 64'(status), 64'b110);
    chk("R4 free unchanged", 64'(free_bytes), 64'd0);
    chk("R6 irq masked", 64'(irq), 64'd0);
    irq_en = 3'b100; tick();
    chk("R6 irq on overrun", 64'(irq), 64'd1);
    pop_one(8'h01, "R4 contents kept");
    stat_clr = 3'b100; tick(); stat_clr = '0;
    chk("R6 irq after clear", 64'(irq), 64'd0);
    chk("R5 full stays", 64'(status), 64'b010);
    irq_en = '0;
    clear_all();
    chk("R10 flush after full", 64'(free_bytes), 64'd256);
  endtask

  task automatic t_rb();
    wr64(64'hA1A2_A3A4_A5A6_A7A8);
    wr64(64'hB1B2_B3B4_B5B6_B7B8);
    wr64(64'hC1C2_C3C4_C5C6_C7C8);
    rb_start = 1'b1; tick(); rb_start = 1'b0;
    chk("R7 busy", 64'(rb_busy), 64'd1);
    chk("R8 frozen", 64'(pop_valid), 64'd0);
    rb_get(64'hA1A2_A3A4_A5A6_A7A8, 1'b0, "R7 word0");
    rb_get(64'hB1B2_B3B4_B5B6_B7B8, 1'b0, "R7 word1");
    rb_get(64'hC1C2_C3C4_C5C6_C7C8, 1'b1, "R7 word2");
    chk("R7 busy ends", 64'(rb_busy), 64'd0);
    chk("R3 free after readback", 64'(free_bytes), 64'd256);
    rb_done_clr = 1'b1; tick(); rb_done_clr = 1'b0;
    chk("R7 done clear", 64'(rb_done), 64'd0);
    rb_start = 1'b1; tick(); rb_start = 1'b0; tick();
    chk("R7 empty done", 64'(rb_done), 64'd1);
    chk("R7 empty no word", 64'(rb_valid), 64'd0);
    clear_all();
  endtask

  task automatic t_freeze();
    logic [63:0] w1 = 64'h1817_1615_1413_1211;
    logic [63:0] w2 = 64'h2827_2625_2423_2221;
    logic [7:0]  got [8];
    int n = 0;
    wr64(w1); wr64(w2);
    for (int i = 0; i < 3; i++) pop_one(w1[8*i +: 8], "R8 pre");
    pop_ready = 1'b1;
    for (int i = 0; i < 12; i++) begin
      if (pop_valid && n < 8) begin got[n] = pop_byte; n++; end
      rb_start = (i == 0);
      tick();
    end
    pop_ready = 1'b0; rb_start = 1'b0;
    chk("R8 partial group count", 64'(n), 64'd5);
    for (int i = 0; i < 5; i++) chk("R8 partial group byte", 64'(got[i]), 64'(w1[8*(i+3) +: 8]));
    chk("R8 word after group", rb_word, w2);
    chk("R7 last done", 64'(rb_done), 64'd1);
    cmd_rd = 1'b1; rb_done_clr = 1'b1; tick(); cmd_rd = 1'b0; rb_done_clr = 1'b0;
    clear_all();
  endtask

  task automatic t_wrclr();
    wr64(64'h3333_3333_3333_3333);
    wr64(64'h4444_4444_4444_4444);
    rb_start = 1'b1; tick(); rb_start = 1'b0; tick();
    chk("R9 busy before write", 64'(rb_busy), 64'd1);
    wr64(64'h5555_5555_5555_5555);
    chk("R9 busy cleared", 64'(rb_busy), 64'd0);
    chk("R9 delivery resumes", 64'(pop_valid), 64'd1);
    chk("R9 free", 64'(free_bytes), 64'd240);
    pop_one(8'h44, "R9 next byte");
    cmd_rd = 1'b1; tick(); cmd_rd = 1'b0;
    clear_all();
  endtask

  task automatic t_flush();
    wr64(64'h6666_6666_6666_6666);
    wr64(64'h7777_7777_7777_7777);
    flush_req = 1'b1; tick(); flush_req = 1'b0;
    chk("R10 empty", 64'(pop_valid), 64'd0);
    chk("R10 free", 64'(free_bytes), 64'd256);
  endtask

  task automatic t_boot();
    wr64(64'h8888_8888_8888_8888);
    boot_off = 1'b1; tick();
    chk("R11 flushed", 64'(pop_valid), 64'd0);
    chk("R11 free large", 64'(free_bytes), 64'd1536);
    for (int i = 0; i < 33; i++) wr64({8{8'(i)}});
    chk("R11 no overrun", 64'(status[2]), 64'd0);
    chk("R11 free", 64'(free_bytes), 64'd1272);
    pop_one(8'h00, "R11 first byte");
    clear_all();
  endtask

  task automatic t_hold();
    exec_hold = 1'b1; tick();
    wr64(64'h9A9A_9A9A_9A9A_9A9A); tick();
    chk("R12 parked on new write", 64'(pop_valid), 64'd0);
    exec_hold = 1'b0; tick();
    chk("R12 resumes", 64'(pop_valid), 64'd1);
    for (int i = 0; i < 8; i++) pop_one(8'h9A, "R12 resumed");
    wr64(64'hB0B0_B0B0_B0B0_B0B0);
    exec_hold = 1'b1; tick();
    for (int i = 0; i < 8; i++) pop_one(8'hB0, "R12 drain queued");
    wr64(64'hC0C0_C0C0_C0C0_C0C0); tick();
    chk("R12 parked after drain", 64'(pop_valid), 64'd0);
    exec_hold = 1'b0; tick();
    pop_one(8'hC0, "R12 release");
    clear_all();
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_order();
    t_full();
    t_rb();
    t_freeze();
    t_wrclr();
    t_flush();
    t_boot();
    t_hold();
    finished = 1;
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
      $finish;
    end
  end
endmodule